// File: doc/BRIEF.md
# Vector Length Decoder and Lane Mask Generator

This block sits in the decode path of a vector unit with a fixed number of lanes. It receives the 3-bit length selector of an instruction, together with the seven scalar registers that may hold an element count. From these it produces three results: a scalar/vector flag, an active-lane count and a per-lane write enable mask. The flag tells the predicate logic where to read the predicate from. In scalar mode the predicate comes from a scalar register. In vector mode it comes from a mask held in a vector register.

The element count may be any unsigned value. It is not limited to powers of two. Lanes numbered at or above the count are disabled. A count larger than the lane budget saturates to all lanes and sets an error flag. The block also provides a clamp helper: it takes the number of elements still to process and returns the smaller of that number and the lane budget. Strip-mined loops can use this to run full-width iterations and finish with one short iteration.

All results are captured on the clock edge that sees the decode strobe. They are presented one cycle later, together with a valid pulse. They hold until the next strobe.

Top module: `vl_lane_decode`

## Requirements
- R1: A selector value of 0 gives scalar mode. `scalar_o`=1, `lane_count_o`=1, `lane_mask_o` has only bit 0 set and `len_err_o`=0, whatever the register contents.
- R2: A selector value n in 1..7 gives vector mode (`scalar_o`=0). The count is read from bits [(n-1)*REG_W +: REG_W] of `len_regs_i`. That slice is the n-th of the seven length registers.
- R3: In vector mode, a count c in 0..MAX_LANES sets `lane_count_o`=c. Bit i of `lane_mask_o` is set exactly when i < c. This holds for counts that are not powers of two.
- R4: A count of 0 in vector mode gives an all-zero mask and `lane_count_o`=0.
- R5: A count of 1 in vector mode gives a mask with only bit 0 set and `lane_count_o`=1, while `scalar_o` stays 0.
- R6: A count greater than MAX_LANES sets `len_err_o`=1, `lane_count_o`=MAX_LANES and an all-ones mask. This comparison uses the full register width. A count equal to MAX_LANES leaves `len_err_o`=0.
- R7: `clamp_o` is the unsigned minimum of `remain_i` and MAX_LANES. It is captured with the same strobe as the other results.
- R8: All results appear on the clock edge that follows a cycle with `dec_valid_i`=1. `out_valid_o` is high in exactly the cycles that follow a strobe cycle.
- R9: In a cycle without a strobe, the registered results keep their values, even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid_i | input | 1 | Decode strobe; captures the inputs |
| vl_sel_i | input | 3 | Length selector field of the instruction |
| len_regs_i | input | 7*REG_W | Seven candidate length registers; slice k is the register picked by selector k+1 |
| remain_i | input | REG_W | Remaining element count for the clamp helper |
| out_valid_o | output | 1 | Pulses one cycle after each strobe |
| scalar_o | output | 1 | 1: predicate from scalar register; 0: mask from vector register |
| lane_count_o | output | $clog2(MAX_LANES+1) | Number of active lanes |
| lane_mask_o | output | MAX_LANES | Per-lane enable, bit i for lane i |
| len_err_o | output | 1 | Count exceeded the lane budget |
| clamp_o | output | REG_W | min(remain_i, MAX_LANES) |

## Verification
The bench builds two instances side by side, both with REG_W=64. One uses the default MAX_LANES=8. The other uses MAX_LANES=5, so that the lane budget is not a power of two. Every selector value is swept against counts from 0 to 12. Together these cover each mask pattern below, at and past both budgets. The sweep adds a count of 2^32+3 and an all-ones count, which show whether the overflow compare truncates the register. While a count is placed in the selected register, the other six registers hold overflow values, so a wrong register pick changes the error flag and the mask.

// File: rtl/vl_lane_pkg.sv
package vl_lane_pkg;
  localparam int SEL_W    = 3;
  localparam int NUM_LREG = 7;

  typedef enum logic {
    MODE_VECTOR = 1'b0,
    MODE_SCALAR = 1'b1
  } vl_mode_e;
endpackage

// File: rtl/vl_sel_decode.sv
module vl_sel_decode
  import vl_lane_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output vl_mode_e         mode_o,
  output logic [SEL_W-1:0] reg_idx_o
);
  always_comb begin
    if (sel_i == '0) begin
      mode_o    = MODE_SCALAR;
      reg_idx_o = '0;
    end else begin
      mode_o    = MODE_VECTOR;
      reg_idx_o = sel_i - SEL_W'(1);
    end
  end
endmodule

// File: rtl/vl_len_select.sv
module vl_len_select
  import vl_lane_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic [NUM_LREG*REG_W-1:0] regs_i,
  input  logic [SEL_W-1:0]          idx_i,
  output logic [REG_W-1:0]          len_o
);
  logic [REG_W-1:0] words [NUM_LREG];

  for (genvar k = 0; k < NUM_LREG; k++) begin : g_unpack
    assign words[k] = regs_i[k*REG_W +: REG_W];
  end

  always_comb begin
    len_o = '0;
    for (int k = 0; k < NUM_LREG; k++) begin
      if (idx_i == SEL_W'(k)) len_o = words[k];
    end
  end
endmodule

// File: rtl/vl_mask_gen.sv
module vl_mask_gen
  import vl_lane_pkg::*;
#(
  parameter int MAX_LANES = 8,
  parameter int REG_W     = 64,
  localparam int CNT_W    = $clog2(MAX_LANES + 1)
) (
  input  logic [REG_W-1:0]     len_i,
  input  vl_mode_e             mode_i,
  output logic [CNT_W-1:0]     count_o,
  output logic [MAX_LANES-1:0] mask_o,
  output logic                 over_o
);
  localparam logic [REG_W-1:0] MAX_W = REG_W'(MAX_LANES);

  function automatic logic [CNT_W-1:0] eff_count(input logic [REG_W-1:0] len,
                                                  input vl_mode_e mode);
    if (mode == MODE_SCALAR)  return CNT_W'(1);
    else if (len > MAX_W)     return CNT_W'(MAX_LANES);
    else                      return len[CNT_W-1:0];
  endfunction

  assign over_o  = (mode_i == MODE_VECTOR) && (len_i > MAX_W);
  assign count_o = eff_count(len_i, mode_i);

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    assign mask_o[i] = (count_o > CNT_W'(i));
  end
endmodule

// File: rtl/vl_clamp.sv
module vl_clamp #(
  parameter int MAX_LANES = 8,
  parameter int REG_W     = 64
) (
  input  logic [REG_W-1:0] remain_i,
  output logic [REG_W-1:0] clamp_o
);
  function automatic logic [REG_W-1:0] umin(input logic [REG_W-1:0] a,
                                             input logic [REG_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  assign clamp_o = umin(remain_i, REG_W'(MAX_LANES));
endmodule

// File: rtl/vl_lane_decode.sv
module vl_lane_decode
  import vl_lane_pkg::*;
#(
  parameter int MAX_LANES = 8,
  parameter int REG_W     = 64,
  localparam int CNT_W    = $clog2(MAX_LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dec_valid_i,
  input  logic [SEL_W-1:0]          vl_sel_i,
  input  logic [NUM_LREG*REG_W-1:0] len_regs_i,
  input  logic [REG_W-1:0]          remain_i,
  output logic                      out_valid_o,
  output logic                      scalar_o,
  output logic [CNT_W-1:0]          lane_count_o,
  output logic [MAX_LANES-1:0]      lane_mask_o,
  output logic                      len_err_o,
  output logic [REG_W-1:0]          clamp_o
);
  vl_mode_e             mode_w;
  logic [SEL_W-1:0]     idx_w;
  logic [REG_W-1:0]     len_w;
  logic [CNT_W-1:0]     count_w;
  logic [MAX_LANES-1:0] mask_w;
  logic                 over_w;
  logic [REG_W-1:0]     clamp_w;
  logic                 capture_w;

  assign capture_w = dec_valid_i;

  vl_sel_decode u_dec (
    .sel_i     (vl_sel_i),
    .mode_o    (mode_w),
    .reg_idx_o (idx_w)
  );

  vl_len_select #(.REG_W(REG_W)) u_sel (
    .regs_i (len_regs_i),
    .idx_i  (idx_w),
    .len_o  (len_w)
  );

  vl_mask_gen #(.MAX_LANES(MAX_LANES), .REG_W(REG_W)) u_mask (
    .len_i   (len_w),
    .mode_i  (mode_w),
    .count_o (count_w),
    .mask_o  (mask_w),
    .over_o  (over_w)
  );

  vl_clamp #(.MAX_LANES(MAX_LANES), .REG_W(REG_W)) u_clamp (
    .remain_i (remain_i),
    .clamp_o  (clamp_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o  <= 1'b0;
      scalar_o     <= 1'b0;
      lane_count_o <= '0;
      lane_mask_o  <= '0;
      len_err_o    <= 1'b0;
      clamp_o      <= '0;
    end else begin
      out_valid_o <= capture_w;
      if (capture_w) begin
        scalar_o     <= (mode_w == MODE_SCALAR);
        lane_count_o <= count_w;
        lane_mask_o  <= mask_w;
        len_err_o    <= over_w;
        clamp_o      <= clamp_w;
      end
    end
  end
endmodule

// File: rtl/vl_lane_decode_chk.sv
module vl_lane_decode_chk
  import vl_lane_pkg::*;
#(
  parameter int MAX_LANES = 8,
  parameter int REG_W     = 64,
  localparam int CNT_W    = $clog2(MAX_LANES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dec_valid_i,
  input logic                 out_valid_o,
  input logic                 scalar_o,
  input logic [CNT_W-1:0]     lane_count_o,
  input logic [MAX_LANES-1:0] lane_mask_o,
  input logic                 len_err_o,
  input logic [REG_W-1:0]     clamp_o
);
  // R8
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> out_valid_o);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> !out_valid_o);

  // R3
  mask_matches_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ($countones(lane_mask_o) == int'(lane_count_o)));

  // R6
  overflow_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_o |-> (&lane_mask_o && !scalar_o));

  // R1
  scalar_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scalar_o |-> (lane_mask_o == MAX_LANES'(1) && !len_err_o));

  // R7
  clamp_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_o <= REG_W'(MAX_LANES));

  // R9
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> ($stable(lane_mask_o) && $stable(clamp_o) && $stable(scalar_o)));
endmodule

bind vl_lane_decode vl_lane_decode_chk #(.MAX_LANES(MAX_LANES), .REG_W(REG_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_valid_i  (dec_valid_i),
  .out_valid_o  (out_valid_o),
  .scalar_o     (scalar_o),
  .lane_count_o (lane_count_o),
  .lane_mask_o  (lane_mask_o),
  .len_err_o    (len_err_o),
  .clamp_o      (clamp_o)
);

// File: tb/vl_lane_decode_tb_top.sv
module vl_lane_decode_tb_top;
  localparam int W   = 64;
  localparam int NR  = 7;
  localparam int MA  = 8;
  localparam int MB  = 5;
  localparam int CWA = $clog2(MA + 1);
  localparam int CWB = $clog2(MB + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dv = 1'b0;
  logic [2:0]      sel = '0;
  logic [NR*W-1:0] regs = '0;
  logic [W-1:0]    remain = '0;

  logic           va, sa, ea, vb, sb, eb;
  logic [CWA-1:0] ca;
  logic [CWB-1:0] cb;
  logic [MA-1:0]  ma;
  logic [MB-1:0]  mb;
  logic [W-1:0]   cla, clb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vl_lane_decode #(.MAX_LANES(MA), .REG_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid_i(dv), .vl_sel_i(sel),
    .len_regs_i(regs), .remain_i(remain), .out_valid_o(va), .scalar_o(sa),
    .lane_count_o(ca), .lane_mask_o(ma), .len_err_o(ea), .clamp_o(cla));

  vl_lane_decode #(.MAX_LANES(MB), .REG_W(W)) dut5_i (
    .clk(clk), .rst_n(rst_n), .dec_valid_i(dv), .vl_sel_i(sel),
    .len_regs_i(regs), .remain_i(remain), .out_valid_o(vb), .scalar_o(sb),
    .lane_count_o(cb), .lane_mask_o(mb), .len_err_o(eb), .clamp_o(clb));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_cnt(input int s, input logic [W-1:0] len, input int mx);
    if (s == 0) return 1;
    if (len > W'(mx)) return W'(mx);
    return len;
  endfunction

  function automatic logic [W-1:0] exp_mask(input logic [W-1:0] c);
    return (W'(1) << c) - W'(1);
  endfunction

  task automatic run_case(input int s, input logic [W-1:0] len, input logic [W-1:0] rem);
    logic [W-1:0] xa, xb;
    @(negedge clk);
    for (int k = 0; k < NR; k++) regs[k*W +: W] = 64'hFFFF_FFFF_0000_0000 + W'(k);
    if (s != 0) regs[(s-1)*W +: W] = len;
    sel = 3'(s);
    remain = rem;
    dv = 1'b1;
    @(negedge clk);
    dv = 1'b0;
    xa = exp_cnt(s, len, MA);
    xb = exp_cnt(s, len, MB);
    chk("R8 valid A", W'(va), 1);
    chk("R8 valid B", W'(vb), 1);
    // R1 R2 R5: scalar flag only for selector 0
    chk("R1/R2 scalar A", W'(sa), (s == 0) ? 1 : 0);
    chk("R1/R2 scalar B", W'(sb), (s == 0) ? 1 : 0);
    // R3 R4 R5 R6: count and mask
    chk("R3 count A", W'(ca), xa);
    chk("R3 count B", W'(cb), xb);
    chk("R3 mask A", W'(ma), exp_mask(xa));
    chk("R3 mask B", W'(mb), exp_mask(xb));
    chk("R6 err A", W'(ea), (s != 0 && len > W'(MA)) ? 1 : 0);
    chk("R6 err B", W'(eb), (s != 0 && len > W'(MB)) ? 1 : 0);
    chk("R7 clamp A", cla, (rem < W'(MA)) ? rem : W'(MA));
    chk("R7 clamp B", clb, (rem < W'(MB)) ? rem : W'(MB));
    // R9: change inputs without a strobe, results must hold
    sel = 3'(s + 3);
    remain = ~rem;
    for (int k = 0; k < NR; k++) regs[k*W +: W] = W'(k + 1);
    @(negedge clk);
    chk("R8 no strobe valid", W'(va), 0);
    chk("R9 hold mask", W'(ma), exp_mask(xa));
    chk("R9 hold count", W'(cb), xb);
    chk("R9 hold clamp", cla, (rem < W'(MA)) ? rem : W'(MA));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset valid", W'(va), 0);
    chk("reset mask", W'(ma), 0);
    chk("reset count", W'(ca), 0);
    chk("reset err", W'(ea), 0);
    chk("reset clamp", cla, 0);
    for (int s = 0; s < 8; s++) begin
      for (int l = 0; l <= 12; l++) run_case(s, W'(l), W'(l * 3 + s));
      run_case(s, 64'h0000_0001_0000_0003, 64'h0000_0001_0000_0002);
      run_case(s, '1, '1);
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule